// File: doc/BRIEF.md
# Double-Edge Reduced-Swing Pixel Output Formatter

This block sits at the output of a panel timing controller. Each rising edge of the pixel clock brings in one 18-bit pixel, six bits for each of red, green and blue, with a data-enable and a fill-select input. It drives nine reduced-swing data lanes, three for each color, and a forwarded clock toward the column drivers. Each lane sends two bits in every clock period. The lower bit of a pair goes out while the clock is high and the upper bit while it is low, so a lane carries twice the pixel rate. For example, an 85 MHz pixel clock gives 170 Mb/s on each lane.

A single-ended line-start pulse is raised one clock period ahead of the first pixel of every line. Once the data-enable has stayed low for longer than one maximum line period, the block treats the panel as being in vertical blanking. It then sends a constant code, all ones or all zeros, in place of the pixel data. The analog drivers and the skew trim are outside the block. The 3-bit skew code is only registered and passed on to them.

Top module: `rsds_pixel_formatter`

## Requirements
- R1: `pix_i` packs red in bits 17:12, green in 11:6 and blue in 5:0. Lane n (0..2) of a color carries color bit 2n while the clock is high and bit 2n+1 while it is low. Lane n of red is `lane_r_o[n]`, of green `lane_g_o[n]` and of blue `lane_b_o[n]`.
- R2: A pixel sampled at rising edge k appears on the lanes from rising edge k+1, with its even bits, and then from falling edge k+1, with its odd bits. No lane changes on both edges for the same bit.
- R3: `fwd_clk_o` is high in the even-bit half and low in the odd-bit half of each period. It is held low in reset and starts at the first high phase that follows a falling edge seen without reset.
- R4: When `de_i` is sampled high at edge k after being sampled low at edge k-1, `sth_o` is high for exactly the period after edge k. This is one period before the first pixel of the line reaches the lanes. At all other times `sth_o` is low.
- R5: A pixel is passed unchanged when `de_i` is high, and also when `de_i` has been low for at most IDLE_LIMIT consecutive samples.
- R6: From the (IDLE_LIMIT+1)-th consecutive low sample of `de_i`, the data word is replaced by all ones when `fill_hi_i` is 1 and by all zeros when it is 0. `fill_hi_i` is sampled together with each word.
- R7: Blanking ends at the first sample with `de_i` high. That pixel is passed, and the low-sample count starts again from zero.
- R8: `skew_o` equals the `skew_i` sampled at the previous rising edge.
- R9: In reset all lanes are 0, `sth_o` is 0, `skew_o` is 0 and the forwarded clock is low. The first word after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_i | input | 18 | Pixel, red 17:12, green 11:6, blue 5:0 |
| de_i | input | 1 | Data enable, high during active pixels |
| fill_hi_i | input | 1 | Blanking code select, 1 all ones, 0 all zeros |
| skew_i | input | 3 | Data-to-clock skew code for the drivers |
| lane_r_o | output | 3 | Red lanes |
| lane_g_o | output | 3 | Green lanes |
| lane_b_o | output | 3 | Blue lanes |
| fwd_clk_o | output | 1 | Forwarded clock |
| sth_o | output | 1 | Line start pulse |
| skew_o | output | 3 | Registered skew code |

## Verification
A walking-one pixel line makes a single bit active at a time. Any swap of lanes, colors or halves then shows up at one specific lane in one specific half-period. Short enable gaps are checked against gaps just past the idle limit, in both fill polarities, with the polarity changed in the middle of blanking. This separates pass-through from substitution at exactly the limit sample and shows that a single enable sample ends blanking. Random line and gap lengths, pixels, fill and skew codes then cover back-to-back lines, zero-length gaps and line starts directly out of blanking. Both half-periods and the forwarded clock level are checked in every cycle.

// File: rtl/rsds_fmt_pkg.sv
`timescale 1ns/1ps
package rsds_fmt_pkg;
    localparam int unsigned COLOR_W    = 6;
    localparam int unsigned NUM_COLORS = 3;
    localparam int unsigned PIX_W      = COLOR_W * NUM_COLORS;
    localparam int unsigned LANES      = PIX_W / 2;
    localparam int unsigned SKEW_W     = 3;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
    } pixel_t;

    // Lane i carries word bit 2i (high half) and 2i+1 (low half).
    function automatic logic [LANES-1:0] phase_bits(pixel_t px, logic odd);
        logic [LANES-1:0] r;
        logic [PIX_W-1:0] flat;
        flat = px;
        for (int i = 0; i < int'(LANES); i++) begin
            r[i] = odd ? flat[2*i+1] : flat[2*i];
        end
        return r;
    endfunction
endpackage

// File: rtl/rsds_blank_detect.sv
`timescale 1ns/1ps
module rsds_blank_detect #(
    parameter int unsigned IDLE_LIMIT = 2047
) (
    input  logic clk,
    input  logic rst,
    input  logic de_i,
    output logic blank_o,
    output logic start_o
);
    localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(IDLE_LIMIT);

    logic [CNT_W-1:0] low_cnt;
    logic             de_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            de_q    <= 1'b0;
        end else begin
            de_q <= de_i;
            if (de_i) begin
                low_cnt <= '0;
            end else if (low_cnt != LIM) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign blank_o = !de_i && (low_cnt == LIM);
    assign start_o = de_i && !de_q;
endmodule

// File: rtl/rsds_ddr_lane.sv
`timescale 1ns/1ps
module rsds_ddr_lane (
    input  logic clk,
    input  logic rst,
    input  logic even_i,
    input  logic odd_i,
    output logic lane_o
);
    logic p_q;
    logic n_q;
    logic odd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q      <= 1'b0;
            odd_hold <= 1'b0;
        end else begin
            p_q      <= even_i ^ n_q;
            odd_hold <= odd_i;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            n_q <= 1'b0;
        end else begin
            n_q <= odd_hold ^ p_q;
        end
    end

    assign lane_o = p_q ^ n_q;
endmodule

// File: rtl/rsds_pixel_formatter.sv
`timescale 1ns/1ps
module rsds_pixel_formatter
    import rsds_fmt_pkg::*;
#(
    parameter int unsigned IDLE_LIMIT = 2047
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              de_i,
    input  logic              fill_hi_i,
    input  logic [SKEW_W-1:0] skew_i,
    output logic [2:0]        lane_r_o,
    output logic [2:0]        lane_g_o,
    output logic [2:0]        lane_b_o,
    output logic              fwd_clk_o,
    output logic              sth_o,
    output logic [SKEW_W-1:0] skew_o
);
    localparam int unsigned PER_COLOR = COLOR_W / 2;

    pixel_t            word_d;
    pixel_t            word_q;
    logic              blank;
    logic              start;
    logic              sth_q;
    logic              run_n;
    logic [SKEW_W-1:0] skew_q;
    logic [LANES-1:0]  even_w;
    logic [LANES-1:0]  odd_w;
    logic [LANES-1:0]  lanes;

    rsds_blank_detect #(.IDLE_LIMIT(IDLE_LIMIT)) u_blank (
        .clk     (clk),
        .rst     (rst),
        .de_i    (de_i),
        .blank_o (blank),
        .start_o (start)
    );

    always_comb begin
        if (blank) begin
            word_d = pixel_t'({PIX_W{fill_hi_i}});
        end else begin
            word_d = pixel_t'(pix_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            sth_q  <= 1'b0;
            skew_q <= '0;
        end else begin
            word_q <= word_d;
            sth_q  <= start;
            skew_q <= skew_i;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            run_n <= 1'b0;
        end else begin
            run_n <= 1'b1;
        end
    end

    assign even_w = phase_bits(word_q, 1'b0);
    assign odd_w  = phase_bits(word_q, 1'b1);

    for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
        rsds_ddr_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .even_i (even_w[i]),
            .odd_i  (odd_w[i]),
            .lane_o (lanes[i])
        );
    end

    assign lane_b_o  = lanes[PER_COLOR-1:0];
    assign lane_g_o  = lanes[2*PER_COLOR-1:PER_COLOR];
    assign lane_r_o  = lanes[3*PER_COLOR-1:2*PER_COLOR];
    assign fwd_clk_o = clk & run_n;
    assign sth_o     = sth_q;
    assign skew_o    = skew_q;
endmodule

// File: rtl/rsds_fmt_checker.sv
`timescale 1ns/1ps
module rsds_fmt_checker
    import rsds_fmt_pkg::*;
#(
    parameter int unsigned IDLE_LIMIT = 2047
) (
    input logic              clk,
    input logic              rst,
    input logic              de_i,
    input logic              fill_hi_i,
    input logic              sth_o,
    input logic [PIX_W-1:0]  pix_i,
    input logic [PIX_W-1:0]  word_q,
    input logic [SKEW_W-1:0] skew_i,
    input logic [SKEW_W-1:0] skew_o
);
    localparam int unsigned CW = $clog2(IDLE_LIMIT + 1);
    localparam logic [CW-1:0] LIMV = CW'(IDLE_LIMIT);

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (de_i) begin
            seen <= '0;
        end else if (seen != LIMV) begin
            seen <= seen + 1'b1;
        end
    end

    AST_PASS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        de_i |=> (word_q == $past(pix_i))); // R5
    AST_BLANK_FILL: assert property (@(posedge clk) disable iff (rst)
        (!de_i && seen == LIMV) |=> (word_q == {PIX_W{$past(fill_hi_i)}})); // R6
    AST_STH_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(de_i) |=> sth_o); // R4
    AST_STH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sth_o |=> !sth_o); // R4
    AST_SKEW_REG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (skew_o == $past(skew_i))); // R8
    AST_RESET_STH: assert property (@(posedge clk)
        rst |=> !sth_o); // R9
endmodule

bind rsds_pixel_formatter rsds_fmt_checker #(.IDLE_LIMIT(IDLE_LIMIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .de_i      (de_i),
    .fill_hi_i (fill_hi_i),
    .sth_o     (sth_o),
    .pix_i     (pix_i),
    .word_q    (word_q),
    .skew_i    (skew_i),
    .skew_o    (skew_o)
);

// File: tb/tb_rsds_pixel_formatter.sv
`timescale 1ns/1ps
module tb_rsds_pixel_formatter;
    localparam int LIM = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] pix_i = '0;
    logic        de_i = 1'b0;
    logic        fill_hi_i = 1'b1;
    logic [2:0]  skew_i = '0;
    logic [2:0]  lane_r_o, lane_g_o, lane_b_o;
    logic        fwd_clk_o, sth_o;
    logic [2:0]  skew_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [17:0] prev_word = '0;
    int          low_run = 0;
    logic        prev_de = 1'b0;
    bit          first_step = 1'b1;

    always #2.5 clk = ~clk;

    rsds_pixel_formatter #(.IDLE_LIMIT(LIM)) dut (
        .clk(clk), .rst(rst), .pix_i(pix_i), .de_i(de_i), .fill_hi_i(fill_hi_i),
        .skew_i(skew_i), .lane_r_o(lane_r_o), .lane_g_o(lane_g_o), .lane_b_o(lane_b_o),
        .fwd_clk_o(fwd_clk_o), .sth_o(sth_o), .skew_o(skew_o)
    );

    function automatic logic [8:0] half_bits(logic [17:0] w, bit odd);
        logic [8:0] r;
        for (int c = 0; c < 3; c++) begin
            for (int n = 0; n < 3; n++) begin
                r[c*3+n] = w[c*6 + 2*n + (odd ? 1 : 0)];
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Drive one input sample and check the outputs of the following period.
    task automatic step(input string tag, input logic [17:0] px, input logic de,
                        input logic fh, input logic [2:0] sk);
        logic [17:0] cur;
        logic        exp_sth;
        pix_i = px; de_i = de; fill_hi_i = fh; skew_i = sk;
        if (!de && low_run == LIM) cur = {18{fh}};
        else cur = px;
        exp_sth = de && !prev_de;
        if (de) low_run = 0;
        else if (low_run < LIM) low_run++;
        prev_de = de;
        @(posedge clk); #1;
        chk({tag, " even half"}, {23'd0, lane_r_o, lane_g_o, lane_b_o}, {23'd0, half_bits(prev_word, 1'b0)});
        chk("R4 line start", {31'd0, sth_o}, {31'd0, exp_sth});
        chk("R8 skew", {29'd0, skew_o}, {29'd0, sk});
        if (!first_step) chk("R3 clock high", {31'd0, fwd_clk_o}, 32'd1);
        @(negedge clk); #1;
        chk({tag, " odd half"}, {23'd0, lane_r_o, lane_g_o, lane_b_o}, {23'd0, half_bits(prev_word, 1'b1)});
        chk("R3 clock low", {31'd0, fwd_clk_o}, 32'd0);
        prev_word = cur;
        first_step = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        pix_i = 18'h2A5A5; de_i = 1'b1; skew_i = 3'd7;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            if (i > 0) begin
                chk("R9 reset lanes", {29'd0, lane_r_o | lane_g_o | lane_b_o}, 32'd0);
                chk("R9 reset sth", {31'd0, sth_o}, 32'd0);
                chk("R9 reset skew", {29'd0, skew_o}, 32'd0);
                chk("R9 reset clock", {31'd0, fwd_clk_o}, 32'd0);
            end
            @(negedge clk); #1;
            if (i > 0) chk("R9 reset lanes low", {29'd0, lane_r_o | lane_g_o | lane_b_o}, 32'd0);
        end
        rst = 1'b0;
        de_i = 1'b0;
        // Walking one over a line: lane and color mapping.
        for (int i = 0; i < 18; i++) step("R1", 18'd1 << i, 1'b1, 1'b1, 3'(i));
        step("R1", 18'h3FFFF, 1'b1, 1'b0, 3'd2);
        // Short gap: pixels pass through.
        for (int i = 0; i < LIM; i++) step("R5", 18'($urandom), 1'b0, 1'b1, 3'd1);
        // Line then long gap with ones fill, switching to zeros fill.
        for (int i = 0; i < 4; i++) step("R2", 18'($urandom), 1'b1, 1'b1, 3'd4);
        for (int i = 0; i < LIM + 6; i++) step("R6", 18'($urandom), 1'b0, 1'b1, 3'd5);
        for (int i = 0; i < 6; i++) step("R6", 18'($urandom), 1'b0, 1'b0, 3'd6);
        // Blanking ends at one enable sample, then count restarts.
        step("R7", 18'h15A3C, 1'b1, 1'b0, 3'd3);
        for (int i = 0; i < LIM + 3; i++) step("R7", 18'($urandom), 1'b0, 1'b0, 3'd0);
        step("R7", 18'h0F0F0, 1'b1, 1'b1, 3'd0);
        // Random lines and gaps.
        for (int ln = 0; ln < 80; ln++) begin
            int act_len;
            int gap_len;
            act_len = 1 + int'($urandom % 30);
            gap_len = int'($urandom % (LIM + 15));
            for (int i = 0; i < act_len; i++)
                step("R2", 18'($urandom), 1'b1, 1'($urandom), 3'($urandom));
            for (int i = 0; i < gap_len; i++)
                step("R5", 18'($urandom), 1'b0, 1'($urandom), 3'($urandom));
        end
        step("R2", 18'h00000, 1'b0, 1'b0, 3'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule